// File: doc/BRIEF.md
# Paired-Counter PWM Generator

This block produces a pulse-width-modulated output from two down-counters working as a pair. The period counter runs continuously. It counts from its reload value down to zero and then starts over. Each time it starts over it raises a one-cycle boundary pulse. The width counter is a one-shot that is re-armed by every boundary pulse. The output is active while the width counter is still counting down, and inactive once it has reached zero.

The count clock arrives as a one-cycle enable strobe on the single system clock. Both reload registers can be written at any time, but a counter only takes a new value when a boundary occurs. A period of P = M+1 count ticks therefore carries min(S, M+1) active ticks, where M is the period reload value and S is the width reload value. A start pulse forces an immediate boundary. A stop pulse freezes both counters and drives the output to its inactive level. A static polarity input selects whether the active level is high or low.

Top module: `pwm_pair_top`

## Requirements
- R1: After reset, both counter outputs read 0, the boundary pulse is low, and the output is at its inactive level.
- R2: A start pulse without stop makes a boundary: one cycle later the boundary pulse is high, the period counter holds the period reload value and the width counter holds the width reload value. This also applies when the pair is already running.
- R3: While running, each enable strobe decrements the period counter. An enable while the counter is 0 instead reloads it and raises the boundary pulse for one cycle, so boundaries are M+1 strobes apart.
- R4: The width counter is loaded at each boundary and then decrements on each enable strobe. Once it reaches 0 it halts until the next boundary.
- R5: The output is active exactly while the width counter is counting. This gives S active strobes out of M+1 when S is at most M+1, and a width reload value of 0 keeps the output inactive.
- R6: When the width reload value is at least M+1, the output stays active through every period.
- R7: A reload write reaches a counter only at the next boundary. If the write happens in the same cycle as a boundary, the counters load the previous values and the new values apply one period later.
- R8: Stop freezes both counters, keeps the boundary pulse low and drives the output inactive until the next start. Stop takes precedence over a start in the same cycle.
- R9: With the polarity input at 1 the active level is high. With it at 0 the active level is low.
- R10: In cycles without an enable strobe or start, neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-clock enable strobe |
| start | input | 1 | Start / restart pulse |
| stop | input | 1 | Stop pulse |
| act_high | input | 1 | 1: active level high, 0: active level low |
| per_we | input | 1 | Period reload write enable |
| per_wdata | input | CNT_W | Period reload write data |
| wid_we | input | 1 | Width reload write enable |
| wid_wdata | input | CNT_W | Width reload write data |
| bnd_irq | output | 1 | One-cycle boundary pulse |
| pwm_out | output | 1 | PWM output |
| per_cnt | output | CNT_W | Current period counter |
| wid_cnt | output | CNT_W | Current width counter |

## Verification
The key collision is a reload write landing in the same cycle as a period boundary. The bench provokes it by writing both registers exactly when the period counter reads 0 and the enable strobe is high. It then checks that the counters first take the old values and only pick up the written ones at the boundary after that. A second collision is start and stop asserted together, which must leave the pair stopped. Start during a running period must restart the sequence at once. Sweeps over small period and width values compare every sampled cycle against a phase computed arithmetically from the tick count.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int unsigned PWM_CNT_W_DEF = 16;

    function automatic logic drive_level(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction

endpackage

// File: rtl/pwm_rld_reg.sv
module pwm_rld_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we) val_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/pwm_period_ch.sv
module pwm_period_ch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         start,
    input  logic         stop,
    input  logic [W-1:0] rld,
    output logic         boundary,
    output logic         irq,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
        logic         irq;
    } per_state_t;

    per_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        boundary = 1'b0;
        if (stop) begin
            st_d.run = 1'b0;
        end else if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = rld;
            st_d.irq = 1'b1;
            boundary = 1'b1;
        end else if (st_q.run && cnt_en) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = rld;
                st_d.irq = 1'b1;
                boundary = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
    assign cnt = st_q.cnt;
endmodule

// File: rtl/pwm_width_ch.sv
module pwm_width_ch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         stop,
    input  logic         boundary,
    input  logic [W-1:0] rld,
    output logic         active,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic         act;
        logic [W-1:0] cnt;
    } wid_state_t;

    wid_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d.act = 1'b0;
        end else if (boundary) begin
            st_d.cnt = rld;
            st_d.act = (rld != '0);
        end else if (st_q.act && cnt_en) begin
            st_d.cnt = st_q.cnt - W'(1);
            st_d.act = (st_q.cnt != W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;
    assign cnt    = st_q.cnt;
endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CNT_W = PWM_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start,
    input  logic             stop,
    input  logic             act_high,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             wid_we,
    input  logic [CNT_W-1:0] wid_wdata,
    output logic             bnd_irq,
    output logic             pwm_out,
    output logic [CNT_W-1:0] per_cnt,
    output logic [CNT_W-1:0] wid_cnt
);
    localparam int unsigned N_RLD = 2;
    localparam int unsigned IDX_PER = 0;
    localparam int unsigned IDX_WID = 1;

    logic [N_RLD-1:0] rld_we;
    logic [CNT_W-1:0] rld_wd [N_RLD];
    logic [CNT_W-1:0] rld_q  [N_RLD];
    logic             boundary;
    logic             wid_active;

    assign rld_we[IDX_PER] = per_we;
    assign rld_we[IDX_WID] = wid_we;
    assign rld_wd[IDX_PER] = per_wdata;
    assign rld_wd[IDX_WID] = wid_wdata;

    for (genvar gi = 0; gi < N_RLD; gi++) begin : g_rld
        pwm_rld_reg #(.W(CNT_W)) u_rld (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (rld_we[gi]),
            .wdata (rld_wd[gi]),
            .val   (rld_q[gi])
        );
    end

    pwm_period_ch #(.W(CNT_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .start    (start),
        .stop     (stop),
        .rld      (rld_q[IDX_PER]),
        .boundary (boundary),
        .irq      (bnd_irq),
        .cnt      (per_cnt)
    );

    pwm_width_ch #(.W(CNT_W)) u_wid (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .stop     (stop),
        .boundary (boundary),
        .rld      (rld_q[IDX_WID]),
        .active   (wid_active),
        .cnt      (wid_cnt)
    );

    assign pwm_out = drive_level(wid_active, act_high);
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             start,
    input logic             stop,
    input logic             act_high,
    input logic             per_we,
    input logic [CNT_W-1:0] per_wdata,
    input logic             wid_we,
    input logic [CNT_W-1:0] wid_wdata,
    input logic             bnd_irq,
    input logic             pwm_out,
    input logic [CNT_W-1:0] per_cnt,
    input logic [CNT_W-1:0] wid_cnt
);
    // R2
    start_makes_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> bnd_irq);

    // R8
    stop_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!bnd_irq && (pwm_out == ~act_high)));

    // R10
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !start) |=> $stable(per_cnt));

    // R10
    wid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !start) |=> $stable(wid_cnt));

    // R5
    idle_width_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_cnt == '0) |-> (pwm_out == ~act_high));

    // R3
    per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !start && !stop && per_cnt != '0) |=>
            (per_cnt == $past(per_cnt) || per_cnt == $past(per_cnt) - CNT_W'(1)));
endmodule

bind pwm_pair_top pwm_pair_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pwm_pair_top_bench.sv
module pwm_pair_top_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0, start = 1'b0, stop = 1'b0, act_high = 1'b1;
    logic         per_we = 1'b0, wid_we = 1'b0;
    logic [W-1:0] per_wdata = '0, wid_wdata = '0;
    logic         bnd_irq, pwm_out;
    logic [W-1:0] per_cnt, wid_cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_pair_top #(.CNT_W(W)) u_pwm_pair_top (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start), .stop(stop),
        .act_high(act_high), .per_we(per_we), .per_wdata(per_wdata),
        .wid_we(wid_we), .wid_wdata(wid_wdata), .bnd_irq(bnd_irq),
        .pwm_out(pwm_out), .per_cnt(per_cnt), .wid_cnt(wid_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_case(input int m, input int s, input int stride, input bit pol, input int ncyc);
        int t;
        bit last_bnd;
        int p;
        p = m + 1;
        @(negedge clk); stop = 1'b1; cnt_en = 1'b0; act_high = pol;
        @(negedge clk); stop = 1'b0;
        per_we = 1'b1; per_wdata = W'(m); wid_we = 1'b1; wid_wdata = W'(s);
        @(negedge clk); per_we = 1'b0; wid_we = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        t = 0; last_bnd = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            int ph, exp_w;
            bit exp_act, en;
            ph = t % p;
            exp_act = (ph < s);
            exp_w = exp_act ? (s - ph) : 0;
            chk(bnd_irq == last_bnd, (stride > 1) ? "R10 irq" : "R3 irq", int'(bnd_irq), int'(last_bnd));
            chk(int'(per_cnt) == m - ph, (stride > 1) ? "R10 per_cnt" : "R3 per_cnt", int'(per_cnt), m - ph);
            chk(int'(wid_cnt) == exp_w, "R4 wid_cnt", int'(wid_cnt), exp_w);
            chk(pwm_out == (pol ? exp_act : !exp_act),
                !pol ? "R9 pwm_out" : ((s >= p) ? "R6 pwm_out" : "R5 pwm_out"),
                int'(pwm_out), int'(pol ? exp_act : !exp_act));
            en = ((c % stride) == (stride - 1));
            cnt_en = en;
            @(negedge clk);
            if (en) begin
                t++;
                last_bnd = ((t % p) == 0);
            end else begin
                last_bnd = 1'b0;
            end
        end
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(per_cnt == '0, "R1 per_cnt", int'(per_cnt), 0);
        chk(wid_cnt == '0, "R1 wid_cnt", int'(wid_cnt), 0);
        chk(bnd_irq == 1'b0, "R1 irq", int'(bnd_irq), 0);
        chk(pwm_out == 1'b0, "R1 pwm_out", int'(pwm_out), 0);

        // R3 R4 R5 R6 sweep
        for (int m = 0; m < 5; m++)
            for (int s = 0; s < 7; s++)
                run_case(m, s, 1, 1'b1, 2 * (m + 1) + 2);
        // R10 sparse strobes, R9 inverted polarity
        run_case(3, 2, 3, 1'b1, 30);
        run_case(4, 1, 2, 1'b1, 24);
        run_case(3, 2, 1, 1'b0, 10);
        run_case(2, 0, 1, 1'b0, 8);
        run_case(2, 5, 2, 1'b0, 14);

        // R7: write in the boundary cycle
        @(negedge clk); act_high = 1'b1;
        per_we = 1'b1; per_wdata = 4'd3; wid_we = 1'b1; wid_wdata = 4'd1;
        @(negedge clk); per_we = 1'b0; wid_we = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(per_cnt == 4'd0, "R7 pre-boundary per_cnt", int'(per_cnt), 0);
        per_we = 1'b1; per_wdata = 4'd5; wid_we = 1'b1; wid_wdata = 4'd4;
        @(negedge clk); per_we = 1'b0; wid_we = 1'b0;
        chk(per_cnt == 4'd3, "R7 old period used", int'(per_cnt), 3);
        chk(wid_cnt == 4'd1, "R7 old width used", int'(wid_cnt), 1);
        chk(bnd_irq == 1'b1, "R7 irq", int'(bnd_irq), 1);
        repeat (4) @(negedge clk);
        chk(per_cnt == 4'd5, "R7 new period", int'(per_cnt), 5);
        chk(wid_cnt == 4'd4, "R7 new width", int'(wid_cnt), 4);
        // R7: mid-period write waits
        per_we = 1'b1; per_wdata = 4'd2;
        @(negedge clk); per_we = 1'b0;
        chk(per_cnt == 4'd4, "R7 mid-period write ignored", int'(per_cnt), 4);
        chk(pwm_out == 1'b1, "R5 active mid-period", int'(pwm_out), 1);

        // R8 stop holds
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        x = int'(per_cnt);
        chk(bnd_irq == 1'b0, "R8 irq low", int'(bnd_irq), 0);
        chk(pwm_out == 1'b0, "R8 output inactive", int'(pwm_out), 0);
        repeat (3) @(negedge clk);
        chk(int'(per_cnt) == x, "R8 per_cnt frozen", int'(per_cnt), x);
        chk(pwm_out == 1'b0, "R8 still inactive", int'(pwm_out), 0);
        // R8 stop beats start
        stop = 1'b1; start = 1'b1;
        @(negedge clk); stop = 1'b0; start = 1'b0;
        chk(bnd_irq == 1'b0, "R8 stop wins irq", int'(bnd_irq), 0);
        @(negedge clk);
        chk(int'(per_cnt) == x, "R8 stop wins per_cnt", int'(per_cnt), x);
        // R2 start restarts from reload (5 -> now 2 in register)
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(bnd_irq == 1'b1, "R2 irq", int'(bnd_irq), 1);
        chk(per_cnt == 4'd2, "R2 per_cnt", int'(per_cnt), 2);
        chk(wid_cnt == 4'd4, "R2 wid_cnt", int'(wid_cnt), 4);
        @(negedge clk);
        chk(per_cnt == 4'd1, "R3 counting after start", int'(per_cnt), 1);
        // R2 start while running
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(bnd_irq == 1'b1, "R2 restart irq", int'(bnd_irq), 1);
        chk(per_cnt == 4'd2, "R2 restart per_cnt", int'(per_cnt), 2);
        cnt_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule